// File: doc/BRIEF.md
# Two-Miss Hysteresis Branch Direction Table

This block predicts whether a conditional branch will be taken. It holds a direct-mapped table of two-bit entries. Each entry is addressed by a slice of the fetch address just above its two byte-offset bits. The front end presents a fetch address on the lookup port and gets back, in the same cycle, a taken or not-taken guess from the addressed entry. When a branch resolves further down the pipeline, its address and real outcome arrive on the update port, and the addressed entry is rewritten at the next clock edge.

An entry is not a saturating counter. One bit holds the direction the entry currently predicts. The other bit records whether the most recent prediction from that entry proved correct. A single wrong guess only clears the correct flag and keeps the direction. A second wrong guess in a row reverses the direction. A correct outcome at any point sets the flag again. Branch targets, tag matching and alias detection are left to other blocks. Two addresses that share an index share an entry.

Top module: `hyst_bht`

## Requirements
- R1: While reset is asserted, and right after it is released, every entry predicts not taken (lk_taken = 0) with its correct flag set.
- R2: The entry index is pc[IDX_W+1:2]. Address bits 1:0 and bits above IDX_W+1 do not affect which entry is read or written, so addresses that differ only there alias to the same entry.
- R3: An update whose outcome matches the entry's direction keeps that direction and sets the correct flag. A miss, then a hit, then another miss therefore leaves the direction unchanged.
- R4: An update whose outcome differs from the entry's direction, applied while the correct flag is set, keeps the direction and clears the flag.
- R5: An update whose outcome differs from the entry's direction, applied while the correct flag is clear, reverses the direction and sets the flag. Two consecutive misses therefore flip the prediction.
- R6: When upd_valid is 0, upd_pc and upd_taken have no effect on any entry.
- R7: lk_taken is a combinational function of lk_pc and the stored table. An update in the same cycle to the same index is not forwarded. The lookup shows the new value from the cycle after the update edge.
- R8: An update changes only the entry it addresses. All other entries keep their state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; updates are written on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_pc | input | PC_W | Fetch address to predict |
| lk_taken | output | 1 | Predicted direction for lk_pc (1 = taken) |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Actual outcome of the resolved branch (1 = taken) |

## Verification
A lookup and an update can address the same entry in the same cycle. The bench does this on purpose by holding lk_pc on a branch's address while that branch's outcome is written, and again during a long randomized phase confined to a handful of indices. In that cycle the lookup must return the state from before the edge. The cycle after the edge must show the new state. Both are compared against a behavioural model that applies the update only at the clock edge.

// File: rtl/bht_pkg.sv
package bht_pkg;

    // One predictor entry: current direction plus last-guess-correct flag
    typedef struct packed {
        logic dir;
        logic ok;
    } ent_t;

    localparam ent_t ENT_RESET = '{dir: 1'b0, ok: 1'b1};

endpackage

// File: rtl/bht_index.sv
module bht_index #(
    parameter int PC_W  = 32,
    parameter int IDX_W = 10
) (
    input  logic [PC_W-1:0]  pc,
    output logic [IDX_W-1:0] idx
);
    // Byte-offset bits and high bits play no part in the index
    logic unused_pc_bits;
    assign unused_pc_bits = ^{pc[1:0], pc[PC_W-1:IDX_W+2]};

    assign idx = pc[IDX_W+1:2];
endmodule

// File: rtl/bht_hyst_next.sv
module bht_hyst_next
    import bht_pkg::*;
(
    input  ent_t cur,
    input  logic taken,
    output ent_t nxt
);
    always_comb begin
        nxt = cur;
        if (taken == cur.dir) begin
            nxt.ok = 1'b1;
        end else if (cur.ok) begin
            nxt.ok = 1'b0;
        end else begin
            nxt.dir = taken;
            nxt.ok  = 1'b1;
        end
    end
endmodule

// File: rtl/hyst_bht.sv
module hyst_bht
    import bht_pkg::*;
#(
    parameter int PC_W  = 32,
    parameter int IDX_W = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] lk_pc,
    output logic            lk_taken,
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic            upd_taken
);
    localparam int DEPTH = 1 << IDX_W;

    typedef struct {
        ent_t tbl [DEPTH];
    } st_t;

    st_t s_d, s_q;

    logic [IDX_W-1:0] lk_idx, upd_idx;
    ent_t             lk_ent, upd_cur, upd_nxt;

    bht_index #(.PC_W(PC_W), .IDX_W(IDX_W)) lk_ix_i (
        .pc  (lk_pc),
        .idx (lk_idx)
    );

    bht_index #(.PC_W(PC_W), .IDX_W(IDX_W)) upd_ix_i (
        .pc  (upd_pc),
        .idx (upd_idx)
    );

    assign lk_ent   = s_q.tbl[lk_idx];
    assign upd_cur  = s_q.tbl[upd_idx];
    assign lk_taken = lk_ent.dir;

    bht_hyst_next nxt_i (
        .cur   (upd_cur),
        .taken (upd_taken),
        .nxt   (upd_nxt)
    );

    always_comb begin
        s_d = s_q;
        if (upd_valid) begin
            s_d.tbl[upd_idx] = upd_nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.tbl <= '{default: ENT_RESET};
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/hyst_bht_chk.sv
module hyst_bht_chk
    import bht_pkg::*;
#(
    parameter int PC_W  = 32,
    parameter int IDX_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic [PC_W-1:0]  lk_pc,
    input logic             lk_taken,
    input logic             upd_valid,
    input logic             upd_taken,
    input logic [IDX_W-1:0] lk_idx,
    input logic [IDX_W-1:0] upd_idx,
    input ent_t             upd_cur,
    input ent_t             upd_nxt
);
    logic same_idx;
    assign same_idx = (lk_idx == upd_idx);

    // R1
    reset_not_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> !lk_taken);

    // R3
    hit_keeps_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_taken == upd_cur.dir) |-> (upd_nxt.dir == upd_cur.dir && upd_nxt.ok));

    // R4
    first_miss_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && same_idx && upd_taken != lk_taken && upd_cur.ok)
        |=> ($stable(lk_pc) -> lk_taken == $past(lk_taken)));

    // R5
    second_miss_flips_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && same_idx && upd_taken != lk_taken && !upd_cur.ok)
        |=> ($stable(lk_pc) -> lk_taken == $past(upd_taken)));

    // R6
    idle_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid |=> ($stable(lk_pc) -> $stable(lk_taken)));

    // R7
    no_forward_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && same_idx) |-> (lk_taken == upd_cur.dir));
endmodule

bind hyst_bht hyst_bht_chk #(.PC_W(PC_W), .IDX_W(IDX_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_pc     (lk_pc),
    .lk_taken  (lk_taken),
    .upd_valid (upd_valid),
    .upd_taken (upd_taken),
    .lk_idx    (lk_idx),
    .upd_idx   (upd_idx),
    .upd_cur   (upd_cur),
    .upd_nxt   (upd_nxt)
);

// File: tb/hyst_bht_tb_top.sv
module hyst_bht_tb_top;
    localparam int PC_W  = 32;
    localparam int IDX_W = 10;
    localparam int DEPTH = 1 << IDX_W;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [PC_W-1:0] lk_pc = '0;
    logic            lk_taken;
    logic            upd_valid = 1'b0;
    logic [PC_W-1:0] upd_pc = '0;
    logic            upd_taken = 1'b0;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 0;
    bit  m_dir [DEPTH];
    bit  m_ok  [DEPTH];

    always #10 clk = ~clk;

    hyst_bht #(.PC_W(PC_W), .IDX_W(IDX_W)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_pc     (lk_pc),
        .lk_taken  (lk_taken),
        .upd_valid (upd_valid),
        .upd_pc    (upd_pc),
        .upd_taken (upd_taken)
    );

    function automatic int ix(input logic [PC_W-1:0] pc);
        return int'((pc >> 2) % DEPTH);
    endfunction

    function automatic void model_reset();
        for (int i = 0; i < DEPTH; i++) begin
            m_dir[i] = 0;
            m_ok[i]  = 1;
        end
    endfunction

    function automatic void model_update(input int i, input bit t);
        if (m_dir[i] == t)  m_ok[i] = 1;
        else if (m_ok[i])   m_ok[i] = 0;
        else begin m_dir[i] = t; m_ok[i] = 1; end
    endfunction

    task automatic check(input string tag);
        bit exp_v;
        exp_v = m_dir[ix(lk_pc)];
        n_chk++;
        if (lk_taken !== exp_v) begin
            n_fail++;
            $display("FAIL %s pc=%h actual=%b expected=%b", tag, lk_pc, lk_taken, exp_v);
        end
    endtask

    // Drive at the falling edge, compare before the rising edge, then commit to the model
    task automatic step(input logic [PC_W-1:0] lpc, input bit v,
                        input logic [PC_W-1:0] upc, input bit t, input string tag);
        @(negedge clk);
        lk_pc = lpc; upd_valid = v; upd_pc = upc; upd_taken = t;
        #3;
        check(tag);
        @(posedge clk);
        if (v) model_update(ix(upc), t);
    endtask

    task automatic look(input logic [PC_W-1:0] lpc, input string tag);
        step(lpc, 0, 32'h0, 0, tag);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            finish_run();
        end
    end

    initial begin
        model_reset();
        // R1: during reset
        #5;
        lk_pc = 32'h0000_0040; #1; check("R1");
        lk_pc = 32'h0000_0ffc; #1; check("R1");
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        look(32'h0000_0040, "R1");
        look(32'h1234_5678, "R1");

        // R4: single miss does not flip
        step(32'h0000_0104, 1, 32'h0000_0104, 1, "R7");
        look(32'h0000_0104, "R4");
        // R3: hit restores flag, next miss does not flip
        step(32'h0000_0104, 1, 32'h0000_0104, 0, "R3");
        step(32'h0000_0104, 1, 32'h0000_0104, 1, "R3");
        look(32'h0000_0104, "R3");
        // R5: second miss in a row flips; same-cycle lookup shows old value (R7)
        step(32'h0000_0104, 1, 32'h0000_0104, 1, "R7");
        look(32'h0000_0104, "R5");
        // R2: aliases share the entry; neighbour does not (R8)
        look(32'h0000_0107, "R2");
        look(32'h0000_0104 + (32'h1 << (IDX_W + 2)), "R2");
        look(32'h0000_0108, "R8");
        look(32'h0000_0100, "R8");
        // R2: update through an alias address flips back
        step(32'h0000_0104, 1, 32'h8000_0106, 0, "R2");
        step(32'h0000_0104, 1, 32'h4000_0105, 0, "R2");
        look(32'h0000_0104, "R5");
        // R6: invalid updates ignored
        step(32'h0000_0200, 0, 32'h0000_0200, 1, "R6");
        step(32'h0000_0200, 0, 32'h0000_0200, 1, "R6");
        look(32'h0000_0200, "R6");
        step(32'h0000_0200, 1, 32'h0000_0200, 1, "R6");
        look(32'h0000_0200, "R6");

        // Random phase over a few indices, lookup often colliding with update
        for (int k = 0; k < 400; k++) begin
            logic [PC_W-1:0] a, b;
            a = {$urandom} & 32'h0000_001f | ({$urandom} & 32'h3000_0000);
            b = ($urandom % 3 == 0) ? ({$urandom} & 32'h0000_001f) : a;
            step(b, ($urandom % 4) != 0, a, $urandom % 2, "R7");
        end

        done = 1;
        finish_run();
    end
endmodule